// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block is the hardware handshake logic of one asynchronous serial channel. On the receive side it watches the fill level of the receive FIFO and drives the active-low request-to-send line with hysteresis. The line is released (driven high) once the level climbs to a negate threshold. It is driven low again only after the level has fallen to a lower reassert threshold. Both thresholds come from a fixed table indexed by the receive trigger select. The block does not stop data from arriving: the FIFO keeps accepting characters after RTS goes high, until it is full.

On the transmit side the active-low clear-to-send input passes through a two-flop synchronizer and then gates the transmitter. A permit signal tells the transmitter whether it may begin a new character. The block follows the transmitter through a start strobe and a character-done strobe, so it never withdraws the permit partway through a character. When CTS goes high mid-character, that character is finished through its stop bit, and only then is the permit withdrawn. The permit returns once the synchronized CTS is low again.

A sticky change flag reports a rising synchronized CTS or a negation of RTS when its enable is set. It is cleared by an acknowledge pulse and is meant as the lowest-priority interrupt source of the channel.

Top module: `uart_hs_flow`

## Requirements
- R1: While and after reset, `rts_n` is 1 and `chg_flag` is 0; with `cts_auto_en` low, `tx_permit` is 1.
- R2: With `rts_auto_en` low, `rts_n` is 1 from the clock edge after any input, whatever the fill level.
- R3: `trig_sel` encodes 0→trigger 1, 1→trigger 4, 2→trigger 8, 3→trigger 14. The negate thresholds are 4, 8, 12 and 14. With `rts_auto_en` high and `rx_level` at or above the negate threshold, `rts_n` is 1 after the next clock edge.
- R4: With `rts_auto_en` high, the reassert thresholds are 1, 4, 8 and 10 (same encoding). When `rx_level` is at or below the reassert threshold, `rts_n` is 0 after the next edge. Strictly between the two thresholds, `rts_n` keeps its value.
- R5: `cts_n` passes through two flops. With `cts_auto_en` high, a low on `cts_n` makes `tx_permit` 1 on the third clock edge after it is applied.
- R6: When the synchronized CTS rises while a character is in flight (after `tx_start`, before `char_done`), `tx_permit` stays 1 until `char_done`. It drops to 0 at the edge that samples `char_done`.
- R7: When the synchronized CTS is high and no character is in flight, `tx_permit` is 0 from the third clock edge after `cts_n` rises.
- R8: With `cts_auto_en` low, `tx_permit` is 1 regardless of `cts_n`.
- R9: With `chg_irq_en` high, a rise of the synchronized CTS or a rise of `rts_n` sets `chg_flag`. The flag stays set until a `chg_ack` pulse clears it, unless a new event arrives in the same cycle.
- R10: With `chg_irq_en` low, `chg_flag` is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_level | input | LVL_W | Receive FIFO fill count |
| trig_sel | input | 2 | Receive trigger select (0:1, 1:4, 2:8, 3:14) |
| rts_auto_en | input | 1 | Enable automatic RTS |
| cts_auto_en | input | 1 | Enable automatic CTS gating |
| chg_irq_en | input | 1 | Enable the change flag |
| chg_ack | input | 1 | Clears the change flag |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_start | input | 1 | Transmitter begins a character |
| char_done | input | 1 | Transmitter has shifted out the stop bit |
| rts_n | output | 1 | Request-to-send, active low |
| tx_permit | output | 1 | Transmitter may start a new character |
| chg_flag | output | 1 | Sticky CTS/RTS change flag |

## Verification
The RTS path is driven with random fill levels, trigger selects and enable toggles, cycle by cycle, against a bench model of the hysteresis. The random stream lands levels above, below and strictly between the two thresholds of every trigger. This separates a correct hold band from an off-by-one compare or a swapped table entry. Directed sequences raise CTS once mid-character and once while idle, which tells a boundary-respecting gate from one that cuts a character short. Further cases disable each enable in turn, so that a flag or gate that ignores its enable shows up.

// File: rtl/uart_hs_flow.sv
module uart_hs_flow #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [1:0]       trig_sel,
  input  logic             rts_auto_en,
  input  logic             cts_auto_en,
  input  logic             chg_irq_en,
  input  logic             chg_ack,
  input  logic             cts_n,
  input  logic             tx_start,
  input  logic             char_done,
  output logic             rts_n,
  output logic             tx_permit,
  output logic             chg_flag
);

  logic [LVL_W-1:0] neg_thr, re_thr;
  always_comb begin
    unique case (trig_sel)
      2'd0:    begin neg_thr = LVL_W'(4);  re_thr = LVL_W'(1);  end
      2'd1:    begin neg_thr = LVL_W'(8);  re_thr = LVL_W'(4);  end
      2'd2:    begin neg_thr = LVL_W'(12); re_thr = LVL_W'(8);  end
      default: begin neg_thr = LVL_W'(14); re_thr = LVL_W'(10); end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !rts_auto_en)    rts_n <= 1'b1;
    else if (rx_level >= neg_thr) rts_n <= 1'b1;
    else if (rx_level <= re_thr)  rts_n <= 1'b0;
  end

  logic cts_m, cts_s, cts_prev, rts_prev, busy, hold;
  always_ff @(posedge clk) begin
    if (rst) begin
      cts_m    <= 1'b1;
      cts_s    <= 1'b1;
      cts_prev <= 1'b1;
      rts_prev <= 1'b1;
      busy     <= 1'b0;
      hold     <= 1'b1;
    end else begin
      cts_m    <= cts_n;
      cts_s    <= cts_m;
      cts_prev <= cts_s;
      rts_prev <= rts_n;
      if (tx_start)       busy <= 1'b1;
      else if (char_done) busy <= 1'b0;
      if (!cts_s)                     hold <= 1'b0;
      else if (!busy || char_done)    hold <= 1'b1;
    end
  end

  assign tx_permit = !cts_auto_en || !hold;

  wire chg_evt = chg_irq_en && ((cts_s && !cts_prev) || (rts_n && !rts_prev));
  always_ff @(posedge clk) begin
    if (rst) chg_flag <= 1'b0;
    else     chg_flag <= chg_evt || (chg_flag && !chg_ack);
  end

  AST_RTS_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !rts_auto_en |=> rts_n); // R2
  AST_RTS_NEGATE: assert property (@(posedge clk) disable iff (rst)
    rts_auto_en && rx_level >= neg_thr |=> rts_n); // R3
  AST_RTS_HOLD_BAND: assert property (@(posedge clk) disable iff (rst)
    rts_auto_en && rx_level > re_thr && rx_level < neg_thr |=> $stable(rts_n)); // R4
  AST_PERMIT_KEPT_MIDCHAR: assert property (@(posedge clk) disable iff (rst)
    busy && !char_done && !tx_start && cts_auto_en && tx_permit |=> tx_permit || !cts_auto_en); // R6
  AST_PERMIT_RESUME: assert property (@(posedge clk) disable iff (rst)
    cts_auto_en && !cts_s |=> tx_permit || !cts_auto_en); // R5
  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (rst)
    !chg_irq_en && (chg_ack || !chg_flag) |=> !chg_flag); // R10
endmodule

// File: tb/test_uart_hs_flow.sv
module test_uart_hs_flow;
  logic clk = 0, rst = 1;
  logic [4:0] rx_level = 0;
  logic [1:0] trig_sel = 0;
  logic rts_auto_en = 0, cts_auto_en = 0, chg_irq_en = 0, chg_ack = 0;
  logic cts_n = 1, tx_start = 0, char_done = 0;
  logic rts_n, tx_permit, chg_flag;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_hs_flow i_uart_hs_flow (
    .clk(clk), .rst(rst), .rx_level(rx_level), .trig_sel(trig_sel),
    .rts_auto_en(rts_auto_en), .cts_auto_en(cts_auto_en), .chg_irq_en(chg_irq_en),
    .chg_ack(chg_ack), .cts_n(cts_n), .tx_start(tx_start), .char_done(char_done),
    .rts_n(rts_n), .tx_permit(tx_permit), .chg_flag(chg_flag));

  function automatic int neg_of(input logic [1:0] s);
    case (s) 2'd0: return 4; 2'd1: return 8; 2'd2: return 12; default: return 14; endcase
  endfunction
  function automatic int re_of(input logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 10; endcase
  endfunction
  function automatic logic next_rts(input logic cur, input logic en, input int lvl, input logic [1:0] s);
    if (!en) return 1'b1;
    if (lvl >= neg_of(s)) return 1'b1;
    if (lvl <= re_of(s)) return 1'b0;
    return cur;
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic model;
    int unsigned seed;
    seed = $urandom(32'd1234);
    cyc(3);
    chk("R1 rts_n in reset", rts_n, 1'b1);
    rst = 0;
    cyc(2);
    chk("R1 rts_n after reset", rts_n, 1'b1);
    chk("R1 chg_flag after reset", chg_flag, 1'b0);
    chk("R1 tx_permit after reset", tx_permit, 1'b1);

    // R3 R4 directed: trigger 14 band
    rts_auto_en = 1; trig_sel = 3; rx_level = 14; cyc(1);
    chk("R3 negate at 14", rts_n, 1'b1);
    rx_level = 11; cyc(1);
    chk("R4 hold at 11", rts_n, 1'b1);
    rx_level = 10; cyc(1);
    chk("R4 reassert at 10", rts_n, 1'b0);
    rx_level = 13; cyc(1);
    chk("R4 hold low at 13", rts_n, 1'b0);
    trig_sel = 0; rx_level = 4; cyc(1);
    chk("R3 negate at 4 for trigger 1", rts_n, 1'b1);
    rx_level = 2; cyc(1);
    chk("R4 hold at 2 for trigger 1", rts_n, 1'b1);
    rx_level = 1; cyc(1);
    chk("R4 reassert at 1 for trigger 1", rts_n, 1'b0);
    rts_auto_en = 0; rx_level = 0; cyc(1);
    chk("R2 disabled at level 0", rts_n, 1'b1);

    // R2 R3 R4 random
    model = rts_n;
    for (int i = 0; i < 3000; i++) begin
      rx_level = 5'($urandom_range(0, 16));
      trig_sel = 2'($urandom_range(0, 3));
      rts_auto_en = ($urandom_range(0, 15) != 0);
      model = next_rts(model, rts_auto_en, int'(rx_level), trig_sel);
      cyc(1);
      chk(rts_auto_en ? "R3/R4 random rts_n" : "R2 random rts_n", rts_n, model);
    end

    // R9 flag from RTS negation
    rts_auto_en = 1; trig_sel = 0; rx_level = 0; cyc(3);
    chg_ack = 1; cyc(1); chg_ack = 0;
    chk("R10 no flag while disabled", chg_flag, 1'b0);
    chg_irq_en = 1; rx_level = 5; cyc(3);
    chk("R9 flag on rts negation", chg_flag, 1'b1);
    cyc(3);
    chk("R9 flag sticky", chg_flag, 1'b1);
    chg_ack = 1; cyc(1); chg_ack = 0; cyc(1);
    chk("R9 flag cleared by ack", chg_flag, 1'b0);

    // R5..R8 CTS gate
    cts_auto_en = 1; cts_n = 0; cyc(2);
    chk("R5 permit not yet after two edges", tx_permit, 1'b0);
    cyc(1);
    chk("R5 permit on third edge", tx_permit, 1'b1);
    tx_start = 1; cyc(1); tx_start = 0;
    cts_n = 1; cyc(6);
    chk("R6 permit kept mid-character", tx_permit, 1'b1);
    chk("R9 flag on cts rise", chg_flag, 1'b1);
    char_done = 1; cyc(1); char_done = 0;
    chk("R6 permit dropped after stop bit", tx_permit, 1'b0);
    chg_ack = 1; cyc(1); chg_ack = 0; cyc(1);
    chk("R9 cleared after cts event", chg_flag, 1'b0);
    cts_n = 0; cyc(3);
    chk("R5 permit resumes", tx_permit, 1'b1);
    chg_irq_en = 0;
    cts_n = 1; cyc(2);
    chk("R7 permit still set before sync", tx_permit, 1'b1);
    cyc(1);
    chk("R7 idle permit drops on third edge", tx_permit, 1'b0);
    chk("R10 no flag on cts rise when disabled", chg_flag, 1'b0);
    cts_auto_en = 0; cyc(1);
    chk("R8 permit with gate off and cts high", tx_permit, 1'b1);
    cyc(4);
    chk("R8 permit stays with gate off", tx_permit, 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule